// File: doc/BRIEF.md
# Wilkinson Gray-Code Conversion Bank

This block is the digital half of a bank of parallel ramp-compare (Wilkinson) converters. A single counter, advanced in Gray code, is shared by every conversion cell of the bank. After a start pulse the counter begins at zero and counts up once per clock. Each cell watches its own comparator-fired input. On the first rising edge seen after the start, the cell stores the counter's current Gray code. The Gray code keeps switching activity low. It also bounds the error of a code caught mid-transition to one count.

When the counter reaches its top value, the window closes. Any cell that has not fired takes the top value, which is its saturated reading. A done flag then rises. Readout is a plain combinational mux: a cell select picks one stored code, and the code is turned from Gray into binary on its way to the output. The bank does no binary conversion at capture time. The default build has 64 cells of 12 bits each, which is one channel's worth of storage cells; wider banks are built by raising the cell count.

Top module: `wilk_gray_bank`

## Requirements
- R1: After reset, `done` is 0 and `sample` reads 0 for every cell select.
- R2: A `start` pulse seen at a clock edge while no conversion runs begins a conversion. From that edge `done` is 0, every cell is re-armed, and the shared count is 0 in the cycle right after that edge (cycle 0).
- R3: In cycle k of a conversion the shared count holds k. A cell whose `fire` bit is sampled high at the end of cycle k, having been sampled low at the previous edge, stores count k.
- R4: A cell keeps only its first rising edge; later rising edges of its `fire` bit in the same conversion change nothing. A `fire` bit that is already high at the start edge and stays high gives no rising edge.
- R5: A cell that has not captured by cycle 2^W-1 (4095) reads the saturated value 2^W-1 (0xFFF). A cell that fires in that last cycle also reads 0xFFF.
- R6: The shared count advances in Gray code, exactly one bit changing per step, and it never wraps within a conversion.
- R7: `sample` is the binary value of the code stored in the cell chosen by `sel`, with no clock of delay.
- R8: `done` rises at the edge that ends cycle 2^W-1, which is 2^W edges after the start edge. It then stays high until the next accepted start.
- R9: A `start` pulse while a conversion runs is ignored: captured values and the `done` timing are unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Conversion clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begins a conversion when idle |
| fire | input | NCELL | Per-cell comparator-fired levels |
| sel | input | $clog2(NCELL) | Cell chosen for readout |
| done | output | 1 | Conversion window closed, results valid |
| sample | output | W | Binary reading of the selected cell |

## Verification
The bench runs four kinds of fire pattern. The first spreads fire times across the whole window, including cycles 0 and 4095. It separates an off-by-one in the count alignment or the Gray decode from a correct capture. The second fires every cell in one cycle, which exposes enable or fan-out faults that only show when all cells capture together. The third mixes cells that never fire, cells already high at start, and cells that pulse twice; these tell saturation and first-edge-only capture apart from edge-blind level capture. The fourth sends a start pulse in the middle of a run, where a design that restarts would shift every later capture and the done time.

// File: rtl/wilk_gray_bank.sv
module wilk_gray_bank #(
  parameter int NCELL = 64,
  parameter int W     = 12,
  localparam int SW   = (NCELL > 1) ? $clog2(NCELL) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [NCELL-1:0] fire,
  input  logic [SW-1:0]    sel,
  output logic             done,
  output logic [W-1:0]     sample
);
  localparam logic [W-1:0] TOP = '1;

  logic             busy;
  logic [W-1:0]     cnt;
  logic [W-1:0]     gray;
  logic [NCELL-1:0] fire_q;
  logic [W-1:0]     codes [NCELL];

  assign gray = cnt ^ (cnt >> 1);

  wire go   = start && !busy;
  wire last = busy && (cnt == TOP);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      done   <= 1'b0;
      cnt    <= '0;
      fire_q <= '0;
    end else begin
      fire_q <= fire;
      if (go) begin
        busy <= 1'b1;
        done <= 1'b0;
        cnt  <= '0;
      end else if (last) begin
        busy <= 1'b0;
        done <= 1'b1;
      end else if (busy) begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  for (genvar i = 0; i < NCELL; i++) begin : g_cell
    logic         got;
    logic [W-1:0] code;
    wire hit = fire[i] && !fire_q[i];

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        got  <= 1'b0;
        code <= '0;
      end else if (go) begin
        got <= 1'b0;
      end else if (busy && !got && (hit || last)) begin
        got  <= 1'b1;
        code <= gray;
      end
    end

    assign codes[i] = code;
  end

  always_comb begin
    logic [W-1:0] g;
    g = codes[sel];
    sample[W-1] = g[W-1];
    for (int k = W - 2; k >= 0; k--)
      sample[k] = sample[k+1] ^ g[k];
  end
endmodule

module wilk_gray_bank_chk #(
  parameter int W = 12
) (
  input logic         clk,
  input logic         rst_n,
  input logic         start,
  input logic         done,
  input logic         busy,
  input logic [W-1:0] cnt,
  input logic [W-1:0] gray
);
  localparam logic [W-1:0] TOP = '1;

  // R6
  gray_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy && $past(busy) && $past(rst_n) |-> $countones(gray ^ $past(gray)) == 1);

  // R8
  done_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(busy) && $past(cnt) == TOP);

  // R8
  done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done && !start |=> done);

  // R2
  start_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start && !busy |=> busy && !done && cnt == '0);

  // R9
  start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start && busy && cnt != TOP |=> busy && cnt == $past(cnt) + 1'b1);

  // R8
  excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && done));
endmodule

bind wilk_gray_bank wilk_gray_bank_chk #(.W(W)) chk_i (
  .clk(clk), .rst_n(rst_n), .start(start), .done(done),
  .busy(busy), .cnt(cnt), .gray(gray)
);

// File: tb/wilk_gray_bank_tb.sv
module wilk_gray_bank_tb_top;
  localparam int PERIOD = 10;
  localparam int N      = 64;
  localparam int W      = 12;
  localparam int TOPV   = (1 << W) - 1;

  logic clk = 0, rst_n = 0, start = 0;
  logic [N-1:0] fire = '0;
  logic [5:0] sel = '0;
  logic done;
  logic [W-1:0] sample;

  int checks = 0, fails = 0;
  int ft [N];
  bit glitch [N];
  bit pre [N];

  always #(PERIOD/2) clk = ~clk;

  wilk_gray_bank #(.NCELL(N), .W(W)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .fire(fire),
    .sel(sel), .done(done), .sample(sample));

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic clear_pattern();
    for (int i = 0; i < N; i++) begin
      ft[i] = -1; glitch[i] = 0; pre[i] = 0;
    end
  endtask

  // runs one conversion; mid >= 0 sends an extra start in that cycle
  task automatic run_conv(input string req, input int mid);
    @(negedge clk);
    for (int i = 0; i < N; i++) fire[i] = pre[i];
    @(negedge clk);
    start = 1;
    @(negedge clk);
    start = 0;
    chk("R2 done cleared", done, 0);
    for (int c = 0; c <= TOPV; c++) begin
      start = (c == mid);
      for (int i = 0; i < N; i++) begin
        if (ft[i] == c) fire[i] = 1;
        if (glitch[i] && c == ft[i] + 1) fire[i] = 0;
        if (glitch[i] && c == ft[i] + 3) fire[i] = 1;
      end
      if (c == TOPV) chk("R8 done low in last cycle", done, 0);
      @(negedge clk);
    end
    start = 0;
    chk("R8 done after terminal", done, 1);
    fire = '0;
    for (int i = 0; i < N; i++) begin
      int exp;
      exp = (ft[i] >= 0 && ft[i] <= TOPV) ? ft[i] : TOPV;
      sel = 6'(i);
      #1;
      chk(req, int'(sample), exp);
    end
  endtask

  task automatic t_reset();
    for (int i = 0; i < N; i += 9) begin
      sel = 6'(i);
      #1;
      chk("R1 sample after reset", int'(sample), 0);
    end
    chk("R1 done after reset", done, 0);
  endtask

  task automatic t_spread();
    clear_pattern();
    for (int i = 0; i < N; i++) ft[i] = (i * 977 + 13) % (TOPV + 1);
    ft[0] = 0; ft[1] = TOPV; ft[2] = 1; ft[3] = TOPV - 1;
    run_conv("R3 R7 spread capture", -1);
    chk("R5 fire in last cycle", ft[1], TOPV);
    repeat (40) @(negedge clk);
    chk("R8 done held", done, 1);
  endtask

  task automatic t_same();
    clear_pattern();
    for (int i = 0; i < N; i++) ft[i] = 2730;
    run_conv("R3 R6 simultaneous capture", -1);
  endtask

  task automatic t_mixed();
    clear_pattern();
    for (int i = 0; i < N; i++) begin
      case (i % 4)
        0: ft[i] = -1;
        1: begin pre[i] = 1; ft[i] = -1; end
        2: begin ft[i] = 100 + i * 31; glitch[i] = 1; end
        default: ft[i] = 3000 + i;
      endcase
    end
    run_conv("R4 R5 first edge and saturation", -1);
  endtask

  task automatic t_midstart();
    clear_pattern();
    for (int i = 0; i < N; i++) ft[i] = 1500 + i * 17;
    run_conv("R9 start while busy ignored", 1200);
  endtask

  initial begin
    #(PERIOD * 200000);
    fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_spread();
    t_same();
    t_mixed();
    t_midstart();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule